// File: doc/BRIEF.md
# Protected Peripheral Clock Gate Controller

This block makes the clock-enable that paces the input debounce filter of a general-purpose I/O port. Four source clocks reach it as one-cycle enable strobes on the system clock. A configuration register picks one source and a power-of-two division ratio, and the block emits a single-cycle enable pulse at the divided rate. Together the source and the ratio set how often the debounce filter samples its input.

The configuration register is guarded by a 16-bit key register. Only one exact key value opens it, and any other value written to the key register closes it again. When the system enters sleep, the selected source stops if its sleep-control bit is set. When the CPU is halted for debug, the block suspends unless a debug-run flag is set. The block also reports two status outputs: whether the debounce filter is live, and whether the filtered input path is active.

Top module: `pclk_gate_ctrl`

## Requirements
- R1: After reset the key register reads 0 (locked), the configuration register reads 0 (source 0, ratio 1, debug-run 0), the error flag reads 0, `clk_en_o` and `filt_run_o` are 0, and `port_in_act_o` is 1.
- R2: Writing exactly 0x0096 to the key register (address 0) unlocks configuration. Writing any other value locks it. A read of address 0 returns 1 in bit 0 while unlocked and 0 while locked.
- R3: The configuration register (address 1) holds the ratio field n in bits [3:0], the source select in bits [5:4] and debug-run in bit 8. A write to it while unlocked updates all three fields, and a read returns them in the same positions.
- R4: A write to address 1 while locked changes nothing and sets a sticky error flag, which reads as bit 0 of address 2. Writing address 2 with bit 0 set clears the flag. Writing it with bit 0 clear leaves the flag unchanged.
- R5: While running, the block emits one `clk_en_o` pulse for every 2^n strobes of the selected source. The pulse appears in the cycle after the strobe that completes the count. Strobes on unselected sources have no effect.
- R6: An accepted write to the configuration register clears the division count.
- R7: In sleep (`sleep_i`=1), if the sleep-control bit of the selected source is 1, no pulses are produced and `filt_run_o` is 0. The division count holds its value.
- R8: In sleep, if that sleep-control bit is 0, pulses continue at the configured rate.
- R9: In debug (`debug_i`=1) with debug-run 0, the block is suspended: no pulses, and the count holds. Counting resumes from the held value once `debug_i` falls.
- R10: While suspended by sleep or debug with `filt_en_i`=1, `port_in_act_o` is 0. Otherwise it is 1. Registers stay writable during suspension.
- R11: With debug-run 1, pulses and `filt_run_o` continue during debug.
- R12: `filt_run_o` is 1 exactly when the block is running (not suspended) and `filt_en_i` is 1, delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_stb_i | input | N_SRC | One enable strobe per source clock |
| sleep_i | input | 1 | System is in sleep |
| debug_i | input | 1 | CPU is halted for debug |
| slp_ctl_i | input | N_SRC | Per-source stop-in-sleep bits |
| filt_en_i | input | 1 | Debounce filter enable bit of the port |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | DATA_W | Registered read data, valid one cycle after the address |
| clk_en_o | output | 1 | Divided clock-enable pulse for the filter |
| filt_run_o | output | 1 | Debounce filter is live |
| port_in_act_o | output | 1 | Filtered input path is active |

## Verification
The assertions assume that writes arrive only through the write strobe, with the address and data stable in that cycle. They also assume that `slp_ctl_i`, `sleep_i`, `debug_i` and `filt_en_i` are plain levels sampled on the same clock. The suspension properties index the sleep-control bits with the registered source select, so they require that the source changes only through the configuration register. The stimulus changes every input on the falling edge and issues at most one write per cycle. It never strobes two sources at once while counting pulses, so each observed pulse can be traced to one selected-source strobe.

// File: rtl/pclk_pkg.sv
package pclk_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] ADR_KEY  = 2'd0;
  localparam logic [REG_AW-1:0] ADR_CFG  = 2'd1;
  localparam logic [REG_AW-1:0] ADR_STAT = 2'd2;
  localparam int CFG_DIV_LSB = 0;
  localparam int CFG_SRC_LSB = 4;
  localparam int CFG_DBG_BIT = 8;
  localparam logic [15:0] UNLOCK_KEY = 16'h0096;
endpackage

// File: rtl/pclk_regs.sv
module pclk_regs
  import pclk_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 4,
  parameter int SRC_W  = 2,
  parameter logic [DATA_W-1:0] KEY = UNLOCK_KEY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              unlocked,
  output logic [SRC_W-1:0]  src_sel,
  output logic [DIV_W-1:0]  div_sel,
  output logic              dbg_run,
  output logic              wr_err,
  output logic              cfg_upd
);
  logic key_wr, cfg_wr, stat_wr;
  logic [DATA_W-1:0] cfg_word, rd_next;

  assign key_wr  = wr_en && (wr_addr == ADR_KEY);
  assign cfg_wr  = wr_en && (wr_addr == ADR_CFG);
  assign stat_wr = wr_en && (wr_addr == ADR_STAT);
  assign cfg_upd = cfg_wr && unlocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      unlocked <= 1'b0;
    end else if (key_wr) begin
      unlocked <= (wr_data == KEY);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_sel <= '0;
      div_sel <= '0;
      dbg_run <= 1'b0;
    end else if (cfg_upd) begin
      div_sel <= wr_data[CFG_DIV_LSB +: DIV_W];
      src_sel <= wr_data[CFG_SRC_LSB +: SRC_W];
      dbg_run <= wr_data[CFG_DBG_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_err <= 1'b0;
    end else if (cfg_wr && !unlocked) begin
      wr_err <= 1'b1;
    end else if (stat_wr && wr_data[0]) begin
      wr_err <= 1'b0;
    end
  end

  always_comb begin
    cfg_word = '0;
    cfg_word[CFG_DIV_LSB +: DIV_W] = div_sel;
    cfg_word[CFG_SRC_LSB +: SRC_W] = src_sel;
    cfg_word[CFG_DBG_BIT] = dbg_run;
  end

  always_comb begin
    rd_next = '0;
    case (rd_addr)
      ADR_KEY:  rd_next[0] = unlocked;
      ADR_CFG:  rd_next = cfg_word;
      ADR_STAT: rd_next[0] = wr_err;
      default:  rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end
endmodule

// File: rtl/pclk_gate.sv
module pclk_gate #(
  parameter int N_SRC = 4,
  parameter int SRC_W = 2
) (
  input  logic [N_SRC-1:0] src_stb,
  input  logic [N_SRC-1:0] slp_ctl,
  input  logic             sleep,
  input  logic             debug,
  input  logic [SRC_W-1:0] src_sel,
  input  logic             dbg_run,
  output logic             running,
  output logic             tick
);
  logic [N_SRC-1:0] src_live;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign src_live[g] = !(sleep && slp_ctl[g]);
  end

  assign running = src_live[src_sel] && !(debug && !dbg_run);
  assign tick    = running && src_stb[src_sel];
endmodule

// File: rtl/pclk_div.sv
module pclk_div #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [DIV_W-1:0] div_sel,
  output logic             pulse
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt, mask;
  logic wrap;

  assign mask = ~({CNT_W{1'b1}} << div_sel);
  assign wrap = (cnt >= mask);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= tick && wrap;
      if (tick) cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pclk_gate_ctrl.sv
module pclk_gate_ctrl
  import pclk_pkg::*;
#(
  parameter int N_SRC  = 4,
  parameter int DATA_W = 16,
  parameter int DIV_W  = 4,
  parameter logic [DATA_W-1:0] KEY = UNLOCK_KEY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_stb_i,
  input  logic              sleep_i,
  input  logic              debug_i,
  input  logic [N_SRC-1:0]  slp_ctl_i,
  input  logic              filt_en_i,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              clk_en_o,
  output logic              filt_run_o,
  output logic              port_in_act_o
);
  localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic             unlocked_w, dbg_run_w, wr_err_w, cfg_upd_w;
  logic [SRC_W-1:0] src_w;
  logic [DIV_W-1:0] div_w;
  logic             running_w, tick_w;

  pclk_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .SRC_W(SRC_W), .KEY(KEY)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
    .rd_addr(rd_addr_i), .rd_data(rd_data_o), .unlocked(unlocked_w), .src_sel(src_w),
    .div_sel(div_w), .dbg_run(dbg_run_w), .wr_err(wr_err_w), .cfg_upd(cfg_upd_w)
  );

  pclk_gate #(.N_SRC(N_SRC), .SRC_W(SRC_W)) gate_i (
    .src_stb(src_stb_i), .slp_ctl(slp_ctl_i), .sleep(sleep_i), .debug(debug_i),
    .src_sel(src_w), .dbg_run(dbg_run_w), .running(running_w), .tick(tick_w)
  );

  pclk_div #(.DIV_W(DIV_W)) div_i (
    .clk(clk), .rst(rst), .clr(cfg_upd_w), .tick(tick_w), .div_sel(div_w), .pulse(clk_en_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_run_o    <= 1'b0;
      port_in_act_o <= 1'b1;
    end else begin
      filt_run_o    <= running_w && filt_en_i;
      port_in_act_o <= running_w || !filt_en_i;
    end
  end
endmodule

// File: rtl/pclk_gate_ctrl_chk.sv
module pclk_gate_ctrl_chk
  import pclk_pkg::*;
#(
  parameter int N_SRC  = 4,
  parameter int DATA_W = 16,
  parameter int SRC_W  = 2,
  parameter int DIV_W  = 4,
  parameter logic [DATA_W-1:0] KEY = UNLOCK_KEY
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic [REG_AW-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              sleep_i,
  input logic              debug_i,
  input logic [N_SRC-1:0]  slp_ctl_i,
  input logic              filt_en_i,
  input logic              clk_en_o,
  input logic              filt_run_o,
  input logic              port_in_act_o,
  input logic              unlocked,
  input logic [SRC_W-1:0]  src_sel,
  input logic [DIV_W-1:0]  div_sel,
  input logic              dbg_run,
  input logic              wr_err
);
  p_key_open_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i == ADR_KEY && wr_data_i == KEY) |=> unlocked);

  p_key_close_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i == ADR_KEY && wr_data_i != KEY) |=> !unlocked);

  p_locked_ignore_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i == ADR_CFG && !unlocked)
      |=> ($stable(src_sel) && $stable(div_sel) && $stable(dbg_run) && wr_err));

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_err && !(wr_en_i && wr_addr_i == ADR_STAT && wr_data_i[0])) |=> wr_err);

  p_sleep_stop_r7: assert property (@(posedge clk) disable iff (rst)
    (sleep_i && slp_ctl_i[src_sel]) |=> (!clk_en_o && !filt_run_o));

  p_dbg_halt_r9: assert property (@(posedge clk) disable iff (rst)
    (debug_i && !dbg_run) |=> (!clk_en_o && !filt_run_o));

  p_in_off_r10: assert property (@(posedge clk) disable iff (rst)
    (debug_i && !dbg_run && filt_en_i) |=> !port_in_act_o);

  p_in_on_r10: assert property (@(posedge clk) disable iff (rst)
    !filt_en_i |=> port_in_act_o);
endmodule

bind pclk_gate_ctrl pclk_gate_ctrl_chk #(
  .N_SRC(N_SRC), .DATA_W(DATA_W), .SRC_W(SRC_W), .DIV_W(DIV_W), .KEY(KEY)
) chk_i (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
  .sleep_i(sleep_i), .debug_i(debug_i), .slp_ctl_i(slp_ctl_i), .filt_en_i(filt_en_i),
  .clk_en_o(clk_en_o), .filt_run_o(filt_run_o), .port_in_act_o(port_in_act_o),
  .unlocked(unlocked_w), .src_sel(src_w), .div_sel(div_w), .dbg_run(dbg_run_w),
  .wr_err(wr_err_w)
);

// File: tb/pclk_gate_ctrl_tb.sv
module pclk_gate_ctrl_tb_top;
  localparam int N_SRC = 4;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_SRC-1:0] src_stb = '0;
  logic sleep = 1'b0, debug = 1'b0, filt_en = 1'b0;
  logic [N_SRC-1:0] slp_ctl = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic clk_en, filt_run, port_in_act;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pclk_gate_ctrl dut_i (
    .clk(clk), .rst(rst), .src_stb_i(src_stb), .sleep_i(sleep), .debug_i(debug),
    .slp_ctl_i(slp_ctl), .filt_en_i(filt_en), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .clk_en_o(clk_en),
    .filt_run_o(filt_run), .port_in_act_o(port_in_act)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output int v);
    rd_addr = a;
    @(negedge clk);
    v = int'(rd_data);
  endtask

  function automatic logic [DW-1:0] cfg(input int dbg, input int s, input int n);
    return DW'((dbg << 8) | (s << 4) | n);
  endfunction

  task automatic strobe(input int s, input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      src_stb = '0; src_stb[s] = 1'b1;
      @(negedge clk);
      if (clk_en) pulses++;
    end
    src_stb = '0;
    @(negedge clk);
    if (clk_en) pulses++;
  endtask

  task automatic t_reset();
    int v;
    check("R1 clk_en", clk_en, 0);
    check("R1 filt_run", filt_run, 0);
    check("R1 port_in_act", port_in_act, 1);
    bus_rd(2'd0, v); check("R1 key read", v, 0);
    bus_rd(2'd1, v); check("R1 cfg read", v, 0);
    bus_rd(2'd2, v); check("R1 err read", v, 0);
  endtask

  task automatic t_protect();
    int v;
    bus_wr(2'd0, 16'h0096); bus_rd(2'd0, v); check("R2 unlock", v, 1);
    bus_wr(2'd0, 16'h0097); bus_rd(2'd0, v); check("R2 relock", v, 0);
    bus_wr(2'd0, 16'h0096);
    bus_wr(2'd1, cfg(1, 3, 9)); bus_rd(2'd1, v); check("R3 cfg fields", v, 16'h0139);
    bus_rd(2'd2, v); check("R3 no err when open", v, 0);
  endtask

  task automatic t_locked_write();
    int v;
    bus_wr(2'd0, 16'h1234);
    bus_wr(2'd1, cfg(0, 1, 2)); bus_rd(2'd1, v); check("R4 locked write ignored", v, 16'h0139);
    bus_rd(2'd2, v); check("R4 err set", v, 1);
    bus_wr(2'd2, 16'h0000); bus_rd(2'd2, v); check("R4 err kept on 0", v, 1);
    bus_wr(2'd2, 16'h0001); bus_rd(2'd2, v); check("R4 err w1c", v, 0);
    bus_wr(2'd0, 16'h0096);
  endtask

  task automatic t_divide();
    int p;
    bus_wr(2'd1, cfg(0, 0, 0)); strobe(0, 3, p); check("R5 div1 pulses", p, 3);
    strobe(3, 3, p); check("R5 other source ignored", p, 0);
    bus_wr(2'd1, cfg(0, 2, 2)); strobe(2, 16, p); check("R5 div4 pulses", p, 4);
    strobe(2, 3, p); check("R5 no early pulse", p, 0);
    strobe(2, 1, p); check("R5 pulse on 4th", p, 1);
  endtask

  task automatic t_counter_clear();
    int p;
    bus_wr(2'd1, cfg(0, 0, 2)); strobe(0, 3, p); check("R6 partial", p, 0);
    bus_wr(2'd1, cfg(0, 0, 2)); strobe(0, 3, p); check("R6 count cleared", p, 0);
    strobe(0, 1, p); check("R6 pulse after clear", p, 1);
  endtask

  task automatic t_sleep();
    int p;
    filt_en = 1'b1;
    bus_wr(2'd1, cfg(0, 1, 1));
    slp_ctl = 4'b0010; sleep = 1'b1;
    strobe(1, 5, p); check("R7 stopped in sleep", p, 0);
    check("R7 filt_run low", filt_run, 0);
    check("R10 input off in sleep", port_in_act, 0);
    sleep = 1'b0;
    strobe(1, 2, p); check("R7 count held", p, 1);
    check("R12 filt_run live", filt_run, 1);
    slp_ctl = 4'b1101; sleep = 1'b1;
    strobe(1, 4, p); check("R8 runs in sleep", p, 2);
    check("R8 filt_run in sleep", filt_run, 1);
    sleep = 1'b0; slp_ctl = '0;
  endtask

  task automatic t_debug();
    int p, v;
    bus_wr(2'd1, cfg(0, 2, 2));
    strobe(2, 3, p); check("R9 partial", p, 0);
    debug = 1'b1;
    strobe(2, 3, p); check("R9 suspended", p, 0);
    check("R10 input off in debug", port_in_act, 0);
    check("R12 filt_run off in debug", filt_run, 0);
    filt_en = 1'b0; @(negedge clk);
    check("R10 input on without filter", port_in_act, 1);
    filt_en = 1'b1;
    bus_wr(2'd0, 16'h0000); bus_rd(2'd0, v); check("R10 writable while halted", v, 0);
    bus_wr(2'd0, 16'h0096);
    debug = 1'b0;
    strobe(2, 1, p); check("R9 resumes from held count", p, 1);
    bus_wr(2'd1, cfg(1, 2, 0));
    debug = 1'b1;
    strobe(2, 3, p); check("R11 runs in debug", p, 3);
    check("R11 filt_run in debug", filt_run, 1);
    check("R11 input active", port_in_act, 1);
    debug = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_protect();
    t_locked_write();
    t_divide();
    t_counter_clear();
    t_sleep();
    t_debug();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule